// File: doc/BRIEF.md
# Field-Split Dictionary Instruction Expander

This block sits between instruction fetch and decode. Every cycle it may take one 32-bit fetched word and decide what it is. An ordinary instruction goes straight through to the issue side. A programming word and the raw data word that follows it write one entry of a runtime-rewritable dictionary. A bundle word carries one or two compressed slots, and each slot is expanded into a full 32-bit instruction.

An instruction is split into three bit fields, and each field has its own dictionary with its own size:

| Field | Instruction bits held | Entry width | Entries |
|---|---|---|---|
| A | opcode, funct3 and funct7 | 17 bits | 8 |
| B | the two register numbers rd and rs1 | 10 bits | 16 |
| C | the rs2/immediate bits | 5 bits | 16 |

A slot holds one index into each dictionary. The three looked-up entries are put back at their original bit positions.

Both sides use valid/ready handshakes. While a bundle is being expanded, fetch is stalled. Expansion sits in the fetch stream with no software step around it. Software only changes what the dictionaries hold, and it does so with programming words placed in the same stream as normal code.

Top module: `fdd_decomp`

## Requirements
- R1: After reset, every dictionary entry is zero, so a bundle slot with any index expands to 32'h0000_0000. With no fetch word offered, out_valid is low.
- R2: A word whose bits [1:0] are not 2'b11 is issued unchanged in the same cycle. Its in_ready equals out_ready.
- R3: A word with bits [1:0] = 2'b11 whose bits [6:0] match neither 7'b0101011 nor 7'b0001011 is also issued unchanged, with in_ready equal to out_ready.
- R4: A programming word has bits [6:0] = 7'b0101011, a field selector in bits [8:7] (0 = A, 1 = B, 2 = C) and an entry index in bits [12:9]; field A uses only index bits [11:9]. The next fetched word is raw data, whatever it looks like. Its low bits (17, 10 or 5) are written on that word's handshake, and the stream then continues normally.
- R5: A bundle word has bits [6:0] = 7'b0001011. Bit 7 gives the slot count (0 = one slot, 1 = two slots). Slot 0 is bits [18:8] and slot 1 is bits [29:19]. Within a slot, bits [2:0] index A, bits [6:3] index B and bits [10:7] index C. The expanded instruction is {A[16:10], C, B[9:5], A[9:7], B[4:0], A[6:0]}.
- R6: Expanded slots are issued one per accepted handshake, slot 0 first. While out_ready is low, out_valid and out_instr are held. in_ready stays low until the last valid slot is accepted, and no extra slot is issued.
- R7: An entry that was just written is used by the very next bundle slot that reads it, even when that bundle is the next fetched word.
- R8: A programming word with field selector 3 consumes its data word and changes no entry.
- R9: Neither the programming word nor its data word is issued (out_valid stays low for both), and both are accepted with in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Block accepts the fetch word |
| in_word | input | 32 | Fetched word |
| out_valid | output | 1 | Instruction available for decode |
| out_ready | input | 1 | Decode accepts the instruction |
| out_instr | output | 32 | Issued or expanded instruction |

## Verification
Two events can meet on adjacent clock edges: a dictionary write on the data word's handshake, and the capture of a bundle that reads that same entry. The bench programs an entry and offers the bundle on the very next fetch cycle. It judges the expansion against a bench-side dictionary model that already holds the new value. A second overlap is a pass-through word offered while decode is stalled: the bench drops out_ready under an offered word and checks that in_ready follows it. Stalls are also placed on chosen slots of swept bundles, to check that the output holds and that fetch stays stalled.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
  localparam int WORD_W   = 32;
  localparam int OPC_W    = 7;
  localparam int A_W      = 17;
  localparam int B_W      = 10;
  localparam int C_W      = 5;
  localparam int A_DEPTH  = 8;
  localparam int B_DEPTH  = 16;
  localparam int C_DEPTH  = 16;
  localparam int A_IW     = $clog2(A_DEPTH);
  localparam int B_IW     = $clog2(B_DEPTH);
  localparam int C_IW     = $clog2(C_DEPTH);
  localparam int SLOT_W   = A_IW + B_IW + C_IW;
  localparam int NSLOT    = 2;
  localparam int SEL_W    = 2;
  localparam int IDX_W    = 4;
  // payload seen by the controller: word bits [29:7]
  localparam int PAY_LSB  = 7;
  localparam int PAY_W    = 1 + NSLOT * SLOT_W;

  localparam logic [OPC_W-1:0] OP_BUNDLE = 7'b0001011;
  localparam logic [OPC_W-1:0] OP_PROG   = 7'b0101011;

  localparam logic [SEL_W-1:0] SEL_A = 2'd0;
  localparam logic [SEL_W-1:0] SEL_B = 2'd1;
  localparam logic [SEL_W-1:0] SEL_C = 2'd2;

  typedef enum logic [1:0] {K_PASS, K_PROG, K_BUNDLE} kind_t;
  typedef enum logic [1:0] {ST_PASS, ST_PDATA, ST_DRAIN} st_t;

  function automatic logic [WORD_W-1:0] join_fields(input logic [A_W-1:0] a,
                                                    input logic [B_W-1:0] b,
                                                    input logic [C_W-1:0] c);
    return {a[16:10], c, b[9:5], a[9:7], b[4:0], a[6:0]};
  endfunction
endpackage

// File: rtl/fdd_rst_sync.sv
module fdd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign srst_n = ff2_q;
endmodule

// File: rtl/fdd_classify.sv
module fdd_classify
  import fdd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output kind_t            kind
);
  always_comb begin
    kind = K_PASS;
    if (opc[1:0] == 2'b11) begin
      if (opc == OP_BUNDLE)    kind = K_BUNDLE;
      else if (opc == OP_PROG) kind = K_PROG;
    end
  end
endmodule

// File: rtl/fdd_dict.sv
module fdd_dict #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic         hit;
    logic [W-1:0] q;
    assign hit = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign ent[g] = q;
  end

  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/fdd_ctrl.sv
module fdd_ctrl
  import fdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  kind_t            kind,
  input  logic [PAY_W-1:0] payload,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             draining,
  output logic             awaiting,
  output logic [A_IW-1:0]  a_idx,
  output logic [B_IW-1:0]  b_idx,
  output logic [C_IW-1:0]  c_idx,
  output logic             we_a,
  output logic             we_b,
  output logic             we_c,
  output logic [IDX_W-1:0] wr_idx
);
  localparam int SL_W = NSLOT * SLOT_W;

  st_t                st_q, st_d;
  logic [SEL_W-1:0]   sel_q;
  logic [IDX_W-1:0]   widx_q;
  logic [SL_W-1:0]    bund_q;
  logic               two_q;
  logic               slot_q, slot_d;
  logic               cap_prog, cap_bund, adv, prog_we;
  logic [SLOT_W-1:0]  cur;

  always_comb begin
    st_d      = st_q;
    slot_d    = slot_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    cap_prog  = 1'b0;
    cap_bund  = 1'b0;
    adv       = 1'b0;
    prog_we   = 1'b0;
    unique case (st_q)
      ST_PASS: begin
        unique case (kind)
          K_PROG: begin
            in_ready = 1'b1;
            if (in_valid) begin
              cap_prog = 1'b1;
              st_d     = ST_PDATA;
            end
          end
          K_BUNDLE: begin
            in_ready = 1'b1;
            if (in_valid) begin
              cap_bund = 1'b1;
              slot_d   = 1'b0;
              st_d     = ST_DRAIN;
            end
          end
          default: begin
            out_valid = in_valid;
            in_ready  = out_ready;
          end
        endcase
      end
      ST_PDATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          prog_we = 1'b1;
          st_d    = ST_PASS;
        end
      end
      ST_DRAIN: begin
        out_valid = 1'b1;
        if (out_ready) begin
          adv = 1'b1;
          if (slot_q == two_q) st_d = ST_PASS;
          else                 slot_d = slot_q + 1'b1;
        end
      end
      default: st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PASS;
      sel_q  <= '0;
      widx_q <= '0;
      bund_q <= '0;
      two_q  <= 1'b0;
      slot_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_prog) begin
        sel_q  <= payload[0 +: SEL_W];
        widx_q <= payload[SEL_W +: IDX_W];
      end
      if (cap_bund) begin
        two_q  <= payload[0];
        bund_q <= payload[1 +: SL_W];
      end
      if (cap_bund || adv) slot_q <= slot_d;
    end
  end

  assign cur      = bund_q[int'(slot_q) * SLOT_W +: SLOT_W];
  assign a_idx    = cur[0 +: A_IW];
  assign b_idx    = cur[A_IW +: B_IW];
  assign c_idx    = cur[A_IW + B_IW +: C_IW];
  assign we_a     = prog_we && (sel_q == SEL_A);
  assign we_b     = prog_we && (sel_q == SEL_B);
  assign we_c     = prog_we && (sel_q == SEL_C);
  assign wr_idx   = widx_q;
  assign draining = (st_q == ST_DRAIN);
  assign awaiting = (st_q == ST_PDATA);
endmodule

// File: rtl/fdd_decomp.sv
module fdd_decomp
  import fdd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_instr
);
  logic             rst_sync_n;
  kind_t            kind;
  logic             drain_w, await_w;
  logic [A_IW-1:0]  a_idx;
  logic [B_IW-1:0]  b_idx;
  logic [C_IW-1:0]  c_idx;
  logic             we_a, we_b, we_c;
  logic [IDX_W-1:0] widx;
  logic [A_W-1:0]   a_ent;
  logic [B_W-1:0]   b_ent;
  logic [C_W-1:0]   c_ent;

  fdd_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  fdd_classify u_cls (.opc(in_word[OPC_W-1:0]), .kind(kind));

  fdd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .kind(kind),
    .payload(in_word[PAY_LSB +: PAY_W]), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .draining(drain_w), .awaiting(await_w),
    .a_idx(a_idx), .b_idx(b_idx), .c_idx(c_idx),
    .we_a(we_a), .we_b(we_b), .we_c(we_c), .wr_idx(widx)
  );

  fdd_dict #(.W(A_W), .DEPTH(A_DEPTH)) u_dict_a (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(we_a), .wr_idx(widx[A_IW-1:0]),
    .wr_data(in_word[A_W-1:0]), .rd_idx(a_idx), .rd_data(a_ent));

  fdd_dict #(.W(B_W), .DEPTH(B_DEPTH)) u_dict_b (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(we_b), .wr_idx(widx[B_IW-1:0]),
    .wr_data(in_word[B_W-1:0]), .rd_idx(b_idx), .rd_data(b_ent));

  fdd_dict #(.W(C_W), .DEPTH(C_DEPTH)) u_dict_c (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(we_c), .wr_idx(widx[C_IW-1:0]),
    .wr_data(in_word[C_W-1:0]), .rd_idx(c_idx), .rd_data(c_ent));

  assign out_instr = drain_w ? join_fields(a_ent, b_ent, c_ent) : in_word;
endmodule

// File: rtl/fdd_chk.sv
module fdd_chk
  import fdd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_instr,
  input logic              draining,
  input logic              awaiting
);
  // R6
  hold_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !out_ready) |=> (out_valid && $stable(out_instr)));

  // R6
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !in_ready);

  // R9
  no_data_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awaiting |-> (!out_valid && in_ready));

  // R4
  prog_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!draining && !awaiting && in_valid && in_word[6:0] == OP_PROG) |=> awaiting);

  // R5
  bundle_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!draining && !awaiting && in_valid && in_word[6:0] == OP_BUNDLE) |=> draining);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!draining && !awaiting && in_valid && in_word[1:0] != 2'b11)
      |-> (out_valid && out_instr == in_word && in_ready == out_ready));
endmodule

bind fdd_decomp fdd_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_instr(out_instr), .draining(drain_w), .awaiting(await_w)
);

// File: tb/test_fdd_decomp.sv
module test_fdd_decomp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_instr;

  int checks = 0;
  int errors = 0;

  logic [16:0] mA [8];
  logic [9:0]  mB [16];
  logic [4:0]  mC [16];

  localparam logic [6:0] BND = 7'b0001011;
  localparam logic [6:0] PRG = 7'b0101011;

  always #10 clk = ~clk;

  fdd_decomp i_fdd_decomp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expand(input logic [2:0] a, input logic [3:0] b,
                                         input logic [3:0] c);
    return {mA[a][16:10], mC[c], mB[b][9:5], mA[a][9:7], mB[b][4:0], mA[a][6:0]};
  endfunction

  function automatic logic [31:0] mkb(input logic two, input logic [2:0] a0,
                                      input logic [3:0] b0, input logic [3:0] c0,
                                      input logic [2:0] a1, input logic [3:0] b1,
                                      input logic [3:0] c1);
    logic [31:0] w;
    w        = 32'h8000_0000;
    w[6:0]   = BND;
    w[7]     = two;
    w[18:8]  = {c0, b0, a0};
    w[29:19] = {c1, b1, a1};
    return w;
  endfunction

  task automatic prog(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_word = {19'd0, idx, sel, PRG};
    #2;
    check("R9 program word not issued", {31'd0, out_valid}, 32'd0);
    check("R9 program word accepted", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_word = data;
    #2;
    check("R9 data word not issued", {31'd0, out_valid}, 32'd0);
    check("R4 data word accepted", {31'd0, in_ready}, 32'd1);
    case (sel)
      2'd0: mA[idx[2:0]] = data[16:0];
      2'd1: mB[idx] = data[9:0];
      2'd2: mC[idx] = data[4:0];
      default: ;
    endcase
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pass_word(input string req, input logic [31:0] w, input logic rdy);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; out_ready = rdy;
    #2;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " data"}, out_instr, w);
    check({req, " ready"}, {31'd0, in_ready}, {31'd0, rdy});
    @(posedge clk);
    #1 in_valid = 1'b0; out_ready = 1'b1;
  endtask

  task automatic bundle(input string req, input logic [31:0] w, input logic [1:0] stall);
    int n;
    n = w[7] ? 2 : 1;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; out_ready = 1'b1;
    #2;
    check({req, " R5 bundle accepted"}, {30'd0, in_ready, out_valid}, 32'd2);
    @(posedge clk);
    #1 in_valid = 1'b0;
    for (int s = 0; s < n; s++) begin
      logic [10:0]  sl;
      logic [31:0]  exp;
      sl  = (s == 0) ? w[18:8] : w[29:19];
      exp = expand(sl[2:0], sl[6:3], sl[10:7]);
      @(negedge clk);
      out_ready = !stall[s];
      #2;
      check({req, " R6 slot valid"}, {31'd0, out_valid}, 32'd1);
      check({req, " R5 slot expansion"}, out_instr, exp);
      check({req, " R6 fetch stalled"}, {31'd0, in_ready}, 32'd0);
      if (stall[s]) begin
        @(negedge clk);
        out_ready = 1'b1;
        #2;
        check({req, " R6 held under stall"}, out_instr, exp);
      end
      @(posedge clk);
    end
    @(negedge clk);
    #2;
    check({req, " R6 no extra slot"}, {31'd0, out_valid}, 32'd0);
    check({req, " R6 fetch resumes"}, {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [6:0] ops [8];
    ops = '{7'b0010011, 7'b0110011, 7'b0000011, 7'b0100011,
            7'b1100011, 7'b1101111, 7'b1100111, 7'b0110111};
    for (int i = 0; i < 8; i++) mA[i] = '0;
    for (int i = 0; i < 16; i++) begin mB[i] = '0; mC[i] = '0; end
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);

    // R1: untouched entries read as zero
    bundle("R1 reset contents", mkb(1'b1, 3'd5, 4'd9, 4'd3, 3'd7, 4'd15, 4'd0), 2'b00);

    // R2: low bits other than 2'b11, with and without downstream stall
    for (int k = 0; k < 24; k++) begin
      logic [31:0] w;
      w = 32'h9E37_79B9 * (k + 1);
      w[1:0] = 2'(k % 3);
      pass_word("R2 pass-through", w, (k % 4) != 0);
    end

    // R3: full-width opcodes that are not markers
    for (int k = 0; k < 8; k++)
      pass_word("R3 plain opcode", {25'h1F0_3A5 ^ 25'(k * 1237), ops[k]}, (k % 3) != 0);

    // R4: fill every entry with raw data carrying high garbage
    for (int i = 0; i < 8; i++)  prog(2'd0, 4'(i), 32'hA5A5_0000 ^ (i * 32'h0001_3579));
    for (int i = 0; i < 16; i++) prog(2'd1, 4'(i), 32'hFFFF_F000 | 32'(i * 61 + 11));
    for (int i = 0; i < 16; i++) prog(2'd2, 4'(i), 32'h7777_7700 | 32'(i * 7 + 3));
    // R4: field A ignores index bit 3
    prog(2'd0, 4'd9, 32'h0001_2345);
    // R4: data word that looks like a bundle is only data
    prog(2'd2, 4'd6, 32'h1234_560B);
    pass_word("R4 stream continues after data", 32'h0000_1230, 1'b1);

    // R5/R6: sweep slots, counts and stall positions
    for (int i = 0; i < 16; i++)
      bundle("R5 sweep", mkb((i % 4) != 3, 3'(i % 8), 4'(i), 4'(15 - i),
                            3'((i + 3) % 8), 4'((i * 5) % 16), 4'((i * 7) % 16)),
             {((i + 1) % 3) == 0, (i % 3) == 0});

    // R7: write immediately followed by a bundle reading it
    prog(2'd0, 4'd1, 32'h0001_5A5A);
    bundle("R7 fresh A entry", mkb(1'b0, 3'd1, 4'd0, 4'd6, 3'd0, 4'd0, 4'd0), 2'b00);
    prog(2'd1, 4'd3, 32'h0000_02C7);
    bundle("R7 fresh B entry", mkb(1'b1, 3'd2, 4'd4, 4'd1, 3'd1, 4'd3, 4'd6), 2'b01);

    // R8: selector 3 changes nothing
    prog(2'd3, 4'd2, 32'hFFFF_FFFF);
    bundle("R8 selector 3 ignored", mkb(1'b1, 3'd2, 4'd2, 4'd2, 3'd2, 4'd2, 4'd2), 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule